// File: doc/BRIEF.md
# Split-Register Performance Monitor Unit

This block counts hardware activity for software profiling. It holds one free-running cycle counter and four event counters, each 32 bits wide. Each event counter picks one line of a bank of event-strobe inputs through an 8-bit code, and it adds one in every clock where that line is high while counting is on. When a counter rolls over from all ones to zero, its overflow flag is set. An interrupt line is raised while any flag whose enable bit is set stays pending.

Software reaches the block through a single-cycle register port. Writes take effect at the next clock edge, and reads return the current contents in the same cycle. Control, interrupt enable, overflow status and event selection each have a register of their own. Overflow status is cleared by writing ones. The cycle counter can be slowed so that it advances once every 64 enabled clocks.

Top module: `perfmon_split`

## Requirements
- R1: After reset all five counters, the interrupt enables and the overflow flags are zero, counting is off, and every event code is 0xFF.
- R2: Control register (address 0): bit 0 enables counting, bit 1 zeroes the event counters, bit 2 zeroes the cycle counter, and bit 3 selects the slow cycle mode. A read returns the identification constant in bits 31:24, bit 3 and bit 0 as written, and zero in all other bits, including bits 2:1.
- R3: While enabled, the cycle counter (address 4) adds one per clock in normal mode, and event counter n (address 5+n) adds one in each clock where its selected strobe is high. While disabled, no counter changes unless it is written.
- R4: An event code of 0xFF, or any code not below the number of strobe inputs, stops that counter from counting.
- R5: In slow mode the cycle counter adds one once every 64 enabled clocks, counted from its last reset.
- R6: Bits 1 and 2 of a control write act once. A cycle-counter reset also restarts the divide-by-64 count, and it leaves the event counters untouched. An event-counter reset leaves the cycle counter untouched.
- R7: Overflow flags (address 2) take bit 0 for the cycle counter and bit 1+n for event counter n. A flag is set when its counter increments from 0xFFFFFFFF to 0.
- R8: Writing a 1 to a flag bit clears that flag. Writing a 0 leaves it unchanged.
- R9: If a counter overflows in the same cycle that its flag is written with 1, the flag ends up set.
- R10: Interrupt enables (address 1) use the same bit positions as the flags. irq is high exactly when some flag and its enable bit are both 1.
- R11: The event select register (address 3) holds the code for counter n at bits 8n+7:8n and reads back as written.
- R12: A write to a counter address loads that value and takes priority over an increment in the same cycle. Addresses 9 to 15 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| ev_strobe | input | NUM_STROBES (16) | Event-strobe inputs, selected by code |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest situation to reach is a counter rolling over in exactly the clock when software writes that counter's flag bit with a one. The bench gets there in a directed step: it loads the cycle counter with all ones while counting is on, then issues the write-1-to-clear in the next cycle. The slow mode is exercised with a 200-clock run whose tick count is known in advance. Random traffic often loads counters just below all ones, so rollovers mix with enable changes, counter resets and reselection of codes.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 32;
    localparam int CNT_W     = 32;
    localparam int CODE_W    = 8;
    localparam int NUM_EVCNT = 4;
    localparam int NUM_CNT   = NUM_EVCNT + 1;

    localparam logic [ADDR_W-1:0] ADR_CTRL     = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_IEN      = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_OVF      = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_EVSEL    = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_CNT_BASE = 4'd4;

    localparam logic [CODE_W-1:0] CODE_IDLE = 8'hFF;

    localparam int CTL_EN    = 0;
    localparam int CTL_EVRST = 1;
    localparam int CTL_CCRST = 2;
    localparam int CTL_DIV   = 3;

    typedef struct packed {
        logic                        en;
        logic                        div;
        logic [NUM_CNT-1:0]          ien;
        logic [NUM_CNT-1:0]          ovf;
        logic [NUM_EVCNT*CODE_W-1:0] evsel;
    } regs_t;
endpackage

// File: rtl/pmu_prescale.sv
module pmu_prescale #(
    parameter int LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    logic [LOG2-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (clr)
            pre_d = '0;
        else if (run)
            pre_d = pre_q + LOG2'(1);
        tick = run && (&pre_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else
            pre_q <= pre_d;
    end
endmodule

// File: rtl/pmu_strobe_sel.sv
module pmu_strobe_sel
    import perfmon_pkg::*;
#(
    parameter int NUM_STROBES = 16
) (
    input  logic [CODE_W-1:0]      code,
    input  logic [NUM_STROBES-1:0] strobes,
    output logic                   hit
);
    always_comb begin
        hit = 1'b0;
        for (int j = 0; j < NUM_STROBES; j++) begin
            if (code == CODE_W'(j) && strobes[j])
                hit = 1'b1;
        end
    end
endmodule

// File: rtl/pmu_count.sv
module pmu_count #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value,
    output logic         wrap
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (load)
            cnt_d = load_val;
        else if (inc)
            cnt_d = cnt_q + W'(1);
        wrap  = inc && !clr && !load && (&cnt_q);
        value = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/perfmon_split.sv
module perfmon_split
    import perfmon_pkg::*;
#(
    parameter int          NUM_STROBES = 16,
    parameter logic [7:0]  ID_CODE     = 8'h5A,
    parameter int          PRE_LOG2    = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    input  logic [NUM_STROBES-1:0] ev_strobe,
    output logic                   irq
);
    localparam int ID_LSB  = DATA_W - 8;
    localparam int GAP_W   = ID_LSB - (CTL_DIV + 1);

    regs_t st_d, st_q;

    logic wr_ctrl, wr_ien, wr_ovf, wr_evsel;
    logic cc_clr, ev_clr, pre_tick;
    logic [NUM_CNT-1:0]   cnt_inc, cnt_clr, cnt_load, cnt_wrap;
    logic [NUM_EVCNT-1:0] ev_hit;
    logic [CNT_W-1:0]     cnt_val [NUM_CNT];
    logic                 ctl_en, ctl_div;
    logic [CNT_W-1:0]     ccnt_now;

    assign wr_ctrl  = reg_we && (reg_addr == ADR_CTRL);
    assign wr_ien   = reg_we && (reg_addr == ADR_IEN);
    assign wr_ovf   = reg_we && (reg_addr == ADR_OVF);
    assign wr_evsel = reg_we && (reg_addr == ADR_EVSEL);
    assign cc_clr   = wr_ctrl && reg_wdata[CTL_CCRST];
    assign ev_clr   = wr_ctrl && reg_wdata[CTL_EVRST];

    assign ctl_en   = st_q.en;
    assign ctl_div  = st_q.div;
    assign ccnt_now = cnt_val[0];

    pmu_prescale #(.LOG2(PRE_LOG2)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.en),
        .clr   (cc_clr),
        .tick  (pre_tick)
    );

    assign cnt_inc[0] = st_q.en && (!st_q.div || pre_tick);
    assign cnt_clr[0] = cc_clr;

    genvar e;
    generate
        for (e = 0; e < NUM_EVCNT; e++) begin : g_sel
            pmu_strobe_sel #(.NUM_STROBES(NUM_STROBES)) u_sel (
                .code    (st_q.evsel[e*CODE_W +: CODE_W]),
                .strobes (ev_strobe),
                .hit     (ev_hit[e])
            );
            assign cnt_inc[e+1] = st_q.en && ev_hit[e];
            assign cnt_clr[e+1] = ev_clr;
        end
    endgenerate

    genvar k;
    generate
        for (k = 0; k < NUM_CNT; k++) begin : g_cnt
            localparam logic [ADDR_W-1:0] K_ADR = ADR_CNT_BASE + ADDR_W'(k);
            assign cnt_load[k] = reg_we && (reg_addr == K_ADR);
            pmu_count #(.W(CNT_W)) u_cnt (
                .clk      (clk),
                .rst_n    (rst_n),
                .inc      (cnt_inc[k]),
                .clr      (cnt_clr[k]),
                .load     (cnt_load[k]),
                .load_val (reg_wdata),
                .value    (cnt_val[k]),
                .wrap     (cnt_wrap[k])
            );
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.en  = reg_wdata[CTL_EN];
            st_d.div = reg_wdata[CTL_DIV];
        end
        if (wr_ien)
            st_d.ien = reg_wdata[NUM_CNT-1:0];
        if (wr_evsel)
            st_d.evsel = reg_wdata;
        st_d.ovf = (st_q.ovf & ~(wr_ovf ? reg_wdata[NUM_CNT-1:0] : '0)) | cnt_wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en    <= 1'b0;
            st_q.div   <= 1'b0;
            st_q.ien   <= '0;
            st_q.ovf   <= '0;
            st_q.evsel <= {NUM_EVCNT{CODE_IDLE}};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr)
            ADR_CTRL:  reg_rdata = {ID_CODE, {GAP_W{1'b0}}, st_q.div, 2'b00, st_q.en};
            ADR_IEN:   reg_rdata = {{(DATA_W-NUM_CNT){1'b0}}, st_q.ien};
            ADR_OVF:   reg_rdata = {{(DATA_W-NUM_CNT){1'b0}}, st_q.ovf};
            ADR_EVSEL: reg_rdata = st_q.evsel;
            default:   reg_rdata = '0;
        endcase
        for (int i = 0; i < NUM_CNT; i++) begin
            if (reg_addr == ADR_CNT_BASE + ADDR_W'(i))
                reg_rdata = cnt_val[i];
        end
    end

    assign irq = |(st_q.ovf & st_q.ien);
endmodule

// File: rtl/pmu_sva.sv
module pmu_sva
    import perfmon_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic               irq,
    input logic               en,
    input logic               div,
    input logic [NUM_CNT-1:0] ovf,
    input logic [NUM_CNT-1:0] ien,
    input logic [CNT_W-1:0]   ccnt
);
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !reg_we) |=> $stable(ccnt));

    a_r7_cycle_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !div && (&ccnt) && !reg_we) |=> (ovf[0] && ccnt == '0));

    a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !div && (&ccnt) && reg_we && reg_addr == ADR_OVF && reg_wdata[0]) |=> ovf[0]);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf[0] && !(reg_we && reg_addr == ADR_OVF && reg_wdata[0])) |=> ovf[0]);

    a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);

    a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADR_CTRL) |=> (en == $past(reg_wdata[CTL_EN])));
endmodule

bind perfmon_split pmu_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .en        (ctl_en),
    .div       (ctl_div),
    .ovf       (st_q.ovf),
    .ien       (st_q.ien),
    .ccnt      (ccnt_now)
);

// File: tb/sim_perfmon_split.sv
`timescale 1ns/1ps
module sim_perfmon_split;
    localparam logic [7:0] ID = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] ev_strobe = '0;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic        m_en, m_div;
    int          m_pre;
    logic [4:0]  m_ien, m_ovf;
    logic [31:0] m_evsel;
    logic [31:0] m_cnt [5];

    always #10 clk = ~clk;

    perfmon_split u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_strobe(ev_strobe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input int a);
        case (a)
            0: return {ID, 20'b0, m_div, 2'b00, m_en};
            1: return {27'b0, m_ien};
            2: return {27'b0, m_ovf};
            3: return m_evsel;
            4, 5, 6, 7, 8: return m_cnt[a-4];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0: return "R2 ctrl read";
            1: return "R10 ien read";
            2: return "R7 ovf read";
            3: return "R11 evsel read";
            4, 5, 6, 7, 8: return "R3 counter read";
            default: return "R12 unused address";
        endcase
    endfunction

    task automatic rd(input int a, output logic [31:0] v);
        reg_we = 1'b0;
        reg_addr = 4'(a);
        #0.5;
        v = reg_rdata;
    endtask

    task automatic compare_all();
        logic [31:0] v;
        for (int a = 0; a < 10; a++) begin
            rd(a, v);
            chk(tag_of(a), v, exp_read(a));
        end
        chk("R10 irq level", {31'b0, irq}, {31'b0, |(m_ovf & m_ien)});
    endtask

    task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] d, input logic [15:0] ev);
        logic [31:0] n_cnt [5];
        logic [4:0]  wraps;
        logic        cc_clr, ev_clr, inc0, hit;
        logic [7:0]  code;
        reg_we = we; reg_addr = a; reg_wdata = d; ev_strobe = ev;
        cc_clr = we && a == 4'd0 && d[2];
        ev_clr = we && a == 4'd0 && d[1];
        wraps = '0;
        inc0 = m_en && (!m_div || m_pre == 63);
        if (cc_clr) n_cnt[0] = '0;
        else if (we && a == 4'd4) n_cnt[0] = d;
        else if (inc0) begin
            if (m_cnt[0] == 32'hFFFFFFFF) wraps[0] = 1'b1;
            n_cnt[0] = m_cnt[0] + 32'd1;
        end else n_cnt[0] = m_cnt[0];
        for (int i = 0; i < 4; i++) begin
            code = m_evsel[8*i +: 8];
            hit = m_en && code < 8'd16 && ev[code[3:0]];
            if (ev_clr) n_cnt[i+1] = '0;
            else if (we && a == 4'(5 + i)) n_cnt[i+1] = d;
            else if (hit) begin
                if (m_cnt[i+1] == 32'hFFFFFFFF) wraps[i+1] = 1'b1;
                n_cnt[i+1] = m_cnt[i+1] + 32'd1;
            end else n_cnt[i+1] = m_cnt[i+1];
        end
        @(posedge clk);
        if (cc_clr) m_pre = 0;
        else if (m_en) m_pre = (m_pre + 1) % 64;
        m_ovf = (m_ovf & ~((we && a == 4'd2) ? d[4:0] : 5'b0)) | wraps;
        if (we && a == 4'd0) begin m_en = d[0]; m_div = d[3]; end
        if (we && a == 4'd1) m_ien = d[4:0];
        if (we && a == 4'd3) m_evsel = d;
        for (int i = 0; i < 5; i++) m_cnt[i] = n_cnt[i];
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        cyc(1'b1, 4'(a), d, 16'h0);
        compare_all();
    endtask

    task automatic idle(input logic [15:0] ev);
        cyc(1'b0, 4'd0, 32'h0, ev);
        compare_all();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        m_en = 0; m_div = 0; m_pre = 0; m_ien = '0; m_ovf = '0;
        m_evsel = 32'hFFFFFFFF;
        for (int i = 0; i < 5; i++) m_cnt[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        compare_all();
        rd(0, v); chk("R1 ctrl after reset", v, {ID, 24'h0});
        rd(3, v); chk("R1 codes unused after reset", v, 32'hFFFFFFFF);

        // R2 masking of control bits
        wr(0, 32'hFFFFFFFF);
        rd(0, v); chk("R2 ctrl masked readback", v, {ID, 24'h000009});
        wr(0, 32'h0);

        // R11 field layout
        wr(3, 32'h03020100);
        rd(3, v); chk("R11 evsel readback", v, 32'h03020100);

        // R3 counting with two strobe patterns
        wr(0, 32'h7);
        for (int k = 0; k < 10; k++) idle({14'b0, (k % 2 == 0), 1'b1});
        wr(0, 32'h0);
        rd(5, v); chk("R3 counter0 steady strobe", v, 32'd10);
        rd(6, v); chk("R3 counter1 alternating strobe", v, 32'd5);
        rd(4, v); chk("R3 cycle counter", v, 32'd11);
        for (int k = 0; k < 5; k++) idle(16'hFFFF);
        rd(5, v); chk("R3 disabled holds", v, 32'd10);

        // R4 unused and out-of-range codes
        wr(3, 32'h000520FF);
        wr(0, 32'h3);
        for (int k = 0; k < 8; k++) idle(16'hFFFF);
        wr(0, 32'h0);
        rd(5, v); chk("R4 code FF idle", v, 32'd0);
        rd(6, v); chk("R4 code out of range idle", v, 32'd0);
        rd(7, v); chk("R4 valid code counts", v, 32'd8);

        // R6 one-shot reset bits
        wr(0, 32'h4);
        rd(4, v); chk("R6 cycle reset", v, 32'd0);
        rd(7, v); chk("R6 events untouched by cycle reset", v, 32'd8);
        wr(0, 32'h2);
        rd(7, v); chk("R6 event reset", v, 32'd0);
        rd(0, v); chk("R6 reset bits not kept", v, {ID, 24'h0});

        // R12 counter load and unused address
        wr(6, 32'h12345678);
        rd(6, v); chk("R12 counter load", v, 32'h12345678);
        wr(9, 32'hDEADBEEF);
        rd(9, v); chk("R12 unused address reads zero", v, 32'h0);

        // R7 / R10 / R8 cycle counter wrap
        wr(1, 32'h0);
        wr(4, 32'hFFFFFFFE);
        wr(0, 32'h1);
        idle(16'h0);
        idle(16'h0);
        wr(0, 32'h0);
        rd(2, v); chk("R7 cycle wrap flag", v, 32'h1);
        rd(4, v); chk("R7 cycle wrapped value", v, 32'h1);
        chk("R10 irq masked", {31'b0, irq}, 32'h0);
        wr(1, 32'h1);
        chk("R10 irq raised", {31'b0, irq}, 32'h1);
        wr(2, 32'h1E);
        rd(2, v); chk("R8 zero bits keep flag", v, 32'h1);
        wr(2, 32'h1);
        rd(2, v); chk("R8 one clears flag", v, 32'h0);
        chk("R10 irq dropped", {31'b0, irq}, 32'h0);

        // R7 event counter wrap on bit 4
        wr(3, 32'h00FFFFFF);
        wr(8, 32'hFFFFFFFF);
        wr(1, 32'h10);
        wr(0, 32'h1);
        idle(16'h1);
        wr(0, 32'h0);
        rd(2, v); chk("R7 counter3 wrap flag", v, 32'h10);
        chk("R10 irq from counter3", {31'b0, irq}, 32'h1);
        wr(2, 32'h10);

        // R9 overflow and clear in the same cycle
        wr(1, 32'h0);
        wr(0, 32'h1);
        wr(4, 32'hFFFFFFFF);
        wr(2, 32'h1);
        rd(2, v); chk("R9 set wins over clear", v, 32'h1);
        rd(4, v); chk("R9 counter wrapped", v, 32'h0);
        wr(0, 32'h0);
        wr(2, 32'h1F);

        // R5 divide-by-64 mode
        wr(0, 32'hD);
        for (int k = 0; k < 200; k++) idle(16'h0);
        wr(0, 32'h0);
        rd(4, v); chk("R5 slow cycle count", v, 32'd3);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            logic        we;
            int          a;
            logic [31:0] d;
            we = ($urandom_range(0, 99) >= 40);
            a = $urandom_range(0, 9);
            d = $urandom;
            if (a == 0) begin
                d[0] = ($urandom_range(0, 9) < 8);
                d[3] = ($urandom_range(0, 9) == 0);
            end else if (a == 3) begin
                for (int b = 0; b < 4; b++)
                    d[8*b +: 8] = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom_range(0, 20));
            end else if (a >= 4 && a <= 8 && $urandom_range(0, 1) == 1) begin
                d = 32'hFFFFFFFF - 32'($urandom_range(0, 20));
            end
            cyc(we, 4'(a), d, 16'($urandom));
            compare_all();
        end

        done = 1;
        summary();
        $finish;
    end
endmodule